// File: doc/BRIEF.md
# Auxiliary Register Load Unit

This block carries out the "load auxiliary register" operation of a small fixed-point DSP datapath. It owns a bank of eight 16-bit auxiliary registers, a 3-bit pointer that selects one of them, a 9-bit data page register and a 16-bit program counter. An instruction word arrives over a valid/ready handshake. The block decodes it and forms a data memory address. It reads that word over a synchronous memory port, where the data returns one cycle after the request. It then writes the word into the chosen auxiliary register.

Addressing has two forms. In direct form the address is the page register concatenated with a 7-bit offset. In indirect form the address is the content of the register that the pointer selects. That register can then be stepped up or down by one, and the pointer can be reloaded.

When the load target is the same register the pointer selects, the step is dropped and the loaded value is kept. A neighbouring unit sets the page register through a write port. A read port exposes any auxiliary register.

The controller has two named states. In FETCH, `insn_ready` is high. An accepted legal word starts the memory read and takes the transition FETCH to LOAD. An accepted illegal word stays in FETCH. In LOAD, the returned word is written back, the post-step and pointer update are applied, and the transition LOAD to FETCH always follows.

Top module: `arl_unit`

## Requirements
- R1: On synchronous reset all eight auxiliary registers, the pointer, the page register and the program counter read as zero, the state is FETCH and `insn_ready` is 1.
- R2: A word is legal when bits 15..11 equal 5'b00110. Bits 10..8 name the destination register, and bit 7 selects direct (0) or indirect (1) form.
- R3: In direct form the memory address is {page, bits 6..0}, that is page*128 + offset (page 4, offset 10 gives 522).
- R4: A legal word is accepted in FETCH and the read is issued in the same cycle. In the following LOAD cycle `done` is 1 and `insn_ready` is 0. The returned word is written unchanged into the destination at the end of LOAD.
- R5: The program counter advances by exactly one for every accepted word, legal or not.
- R6: In indirect form the memory address is the content of the register the pointer selects at acceptance.
- R7: In indirect form, bits 5..4 of the word select the post-step of the pointed register: 00 none, 01 minus one, 10 plus one, 11 none. The arithmetic wraps in 16 bits, and the step applies at the end of LOAD.
- R8: If, in indirect form, the destination equals the pointed register, the post-step is skipped and that register holds exactly the loaded word.
- R9: In indirect form, bit 3 set loads bits 2..0 into the pointer at the end of LOAD, after the address was taken. With bit 3 clear the pointer is kept.
- R10: An accepted word whose bits 15..11 are not 00110 issues no memory read and changes no auxiliary register or pointer. It raises `illegal` for exactly the one cycle after acceptance.
- R11: `page_we` high at a clock edge loads `page_din` into the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Block can accept a word (FETCH state) |
| insn_word | input | 16 | Instruction word |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| page_we | input | 1 | Page register write enable |
| page_din | input | 9 | Page register write value |
| ar_sel | input | 3 | Auxiliary register read select |
| ar_dout | output | 16 | Selected auxiliary register |
| arp | output | 3 | Current pointer |
| page | output | 9 | Current page register |
| pc | output | 16 | Program counter |
| done | output | 1 | A load is written back this cycle |
| illegal | output | 1 | Previous accepted word was illegal |

## Verification
Direct loads run with a nonzero page, which shows whether the page bits are concatenated or dropped. Indirect loads cover every post-step code with the destination both different from and equal to the pointed register. These patterns separate the plus-one, minus-one and self-target paths, and a pointed register at zero or 0xFFFF exposes missing 16-bit wrap. Words that reload the pointer show that the address was taken with the old pointer. An illegal word between loads shows that nothing but the program counter moves.

// File: rtl/arl_pkg.sv
package arl_pkg;
    localparam int DW    = 16;
    localparam int NREG  = 8;
    localparam int IW    = $clog2(NREG);
    localparam int PGW   = 9;
    localparam int OFFW  = DW - PGW;
    localparam logic [4:0] OPC_LAR = 5'b00110;

    localparam logic [1:0] STEP_NONE = 2'b00;
    localparam logic [1:0] STEP_DEC  = 2'b01;
    localparam logic [1:0] STEP_INC  = 2'b10;

    typedef enum logic [0:0] {S_FETCH, S_LOAD} arl_state_e;

    typedef struct packed {
        logic            legal;
        logic [IW-1:0]   dst;
        logic            indir;
        logic [1:0]      step;
        logic            nxt_en;
        logic [IW-1:0]   nxt_val;
        logic [OFFW-1:0] off;
    } arl_dec_t;

    function automatic arl_dec_t arl_decode(input logic [DW-1:0] w);
        arl_dec_t d;
        d.legal   = (w[15:11] == OPC_LAR);
        d.dst     = w[10:8];
        d.indir   = w[7];
        d.step    = w[5:4];
        d.nxt_en  = w[3];
        d.nxt_val = w[2:0];
        d.off     = w[OFFW-1:0];
        return d;
    endfunction
endpackage

// File: rtl/arl_regfile.sv
module arl_regfile
    import arl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic          md_en,
    input  logic [IW-1:0] md_idx,
    input  logic [DW-1:0] md_data,
    input  logic [IW-1:0] ptr_idx,
    output logic [DW-1:0] ptr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (ld_en && ld_idx == IW'(i))
                regs[i] <= ld_data;
            else if (md_en && md_idx == IW'(i))
                regs[i] <= md_data;
        end
    end

    assign ptr_data = regs[ptr_idx];
    assign rd_data  = regs[rd_idx];

    // R4 R8
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> regs[$past(ld_idx)] == $past(ld_data));

    // R7
    step_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (md_en && !(ld_en && ld_idx == md_idx)) |=> regs[$past(md_idx)] == $past(md_data));
endmodule

// File: rtl/arl_addr.sv
module arl_addr
    import arl_pkg::*;
(
    input  logic            indir,
    input  logic [PGW-1:0]  page_q,
    input  logic [OFFW-1:0] off,
    input  logic [DW-1:0]   ptr_data,
    output logic [DW-1:0]   addr
);
    always_comb begin
        if (indir)
            addr = ptr_data;
        else
            addr = {page_q, off};
    end
endmodule

// File: rtl/arl_ctrl.sv
module arl_ctrl
    import arl_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           insn_valid,
    input  logic [DW-1:0]  insn_word,
    output logic           insn_ready,
    output arl_dec_t       dec,
    output logic           mem_rd,
    input  logic           page_we,
    input  logic [PGW-1:0] page_din,
    output logic [PGW-1:0] page_q,
    input  logic [DW-1:0]  ptr_data,
    output logic [IW-1:0]  arp_q,
    output logic           ld_en,
    output logic [IW-1:0]  ld_idx,
    output logic           md_en,
    output logic [IW-1:0]  md_idx,
    output logic [DW-1:0]  md_data,
    output logic [DW-1:0]  pc_q,
    output logic           illegal_q
);
    arl_state_e state, state_n;
    arl_dec_t   cur;
    logic       fire;

    assign dec  = arl_decode(insn_word);
    assign fire = insn_valid && insn_ready;

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_FETCH: if (fire && dec.legal) state_n = S_LOAD;
            S_LOAD:  state_n = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            pc_q      <= '0;
            arp_q     <= '0;
            page_q    <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= fire && !dec.legal;
            if (fire) begin
                cur  <= dec;
                pc_q <= pc_q + DW'(1);
            end
            if (state == S_LOAD && cur.indir && cur.nxt_en)
                arp_q <= cur.nxt_val;
            if (page_we)
                page_q <= page_din;
        end
    end

    always_comb begin
        insn_ready = (state == S_FETCH);
        mem_rd     = fire && dec.legal;
        ld_en      = (state == S_LOAD);
        ld_idx     = cur.dst;
        md_idx     = arp_q;
        md_en      = ld_en && cur.indir && cur.dst != arp_q &&
                     (cur.step == STEP_DEC || cur.step == STEP_INC);
        md_data    = (cur.step == STEP_DEC) ? ptr_data - DW'(1) : ptr_data + DW'(1);
    end

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> pc_q == $past(pc_q) + DW'(1));

    // R10
    illegal_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !dec.legal) |=> (state == S_FETCH && illegal_q && $stable(arp_q)));

    // R9
    ptr_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOAD && cur.indir && cur.nxt_en) |=> arp_q == $past(cur.nxt_val));

    // R4
    one_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> !ld_en);
endmodule

// File: rtl/arl_unit.sv
module arl_unit
    import arl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        insn_valid,
    output logic        insn_ready,
    input  logic [15:0] insn_word,
    output logic        mem_rd,
    output logic [15:0] mem_addr,
    input  logic [15:0] mem_rdata,
    input  logic        page_we,
    input  logic [8:0]  page_din,
    input  logic [2:0]  ar_sel,
    output logic [15:0] ar_dout,
    output logic [2:0]  arp,
    output logic [8:0]  page,
    output logic [15:0] pc,
    output logic        done,
    output logic        illegal
);
    arl_dec_t      dec;
    logic [DW-1:0] ptr_data, md_data;
    logic          ld_en, md_en;
    logic [IW-1:0] ld_idx, md_idx;

    arl_ctrl u_ctrl (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
        .insn_ready(insn_ready), .dec(dec), .mem_rd(mem_rd),
        .page_we(page_we), .page_din(page_din), .page_q(page),
        .ptr_data(ptr_data), .arp_q(arp), .ld_en(ld_en), .ld_idx(ld_idx),
        .md_en(md_en), .md_idx(md_idx), .md_data(md_data),
        .pc_q(pc), .illegal_q(illegal)
    );

    arl_addr u_addr (
        .indir(dec.indir), .page_q(page), .off(dec.off),
        .ptr_data(ptr_data), .addr(mem_addr)
    );

    arl_regfile u_rf (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(mem_rdata),
        .md_en(md_en), .md_idx(md_idx), .md_data(md_data),
        .ptr_idx(arp), .ptr_data(ptr_data), .rd_idx(ar_sel), .rd_data(ar_dout)
    );

    assign done = ld_en;

    // R3
    direct_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !insn_word[7]) |-> mem_addr == {page, insn_word[6:0]});

    // R10
    no_read_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_word[15:11] != 5'b00110) |-> !mem_rd);
endmodule

// File: tb/arl_unit_tb.sv
module arl_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        insn_valid;
    logic        insn_ready;
    logic [15:0] insn_word;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        page_we;
    logic [8:0]  page_din;
    logic [2:0]  ar_sel;
    logic [15:0] ar_dout;
    logic [2:0]  arp;
    logic [8:0]  page;
    logic [15:0] pc;
    logic        done;
    logic        illegal;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] mem [1024];
    logic [15:0] m_ar [8];
    logic [2:0]  m_arp;
    logic [8:0]  m_page;
    logic [15:0] m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    arl_unit u_dut (.*);

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        for (int i = 0; i < 8; i++) begin
            ar_sel = 3'(i);
            #1;
            chk(tag, ar_dout, m_ar[i]);
        end
        chk(tag, 16'(arp), 16'(m_arp));
        chk(tag, pc, m_pc);
        chk(tag, 16'(page), 16'(m_page));
    endtask

    task automatic set_page(input logic [8:0] p);
        @(negedge clk);
        page_we = 1'b1; page_din = p;
        @(negedge clk);
        page_we = 1'b0;
        m_page = p;
        chk("R11 page write", 16'(page), 16'(p));
    endtask

    // issue one load; the model below is written from R2..R9
    task automatic lar(input logic [2:0] dst, input logic ind, input logic [1:0] step,
                       input logic nen, input logic [2:0] nv, input logic [6:0] off,
                       input string tag);
        logic [15:0] a, d;
        @(negedge clk);
        insn_word  = {5'b00110, dst, ind, ind ? {1'b0, step, nen, nv} : off};
        insn_valid = 1'b1;
        a = ind ? m_ar[m_arp] : {m_page, off};
        d = mem[a[9:0]];
        #1;
        chk({tag, " R3/R6 addr"}, mem_addr, a);
        chk({tag, " R4 read"}, 16'(mem_rd), 16'd1);
        @(negedge clk);
        insn_valid = 1'b0;
        chk({tag, " R4 done"}, 16'(done), 16'd1);
        chk({tag, " R4 ready low"}, 16'(insn_ready), 16'd0);
        if (ind && dst != m_arp && step == 2'b01) m_ar[m_arp] = m_ar[m_arp] - 16'd1;
        if (ind && dst != m_arp && step == 2'b10) m_ar[m_arp] = m_ar[m_arp] + 16'd1;
        m_ar[dst] = d;
        if (ind && nen) m_arp = nv;
        m_pc = m_pc + 16'd1;
        @(negedge clk);
        chk_state(tag);
    endtask

    task automatic t_reset;
        chk_state("R1 reset");
        chk("R1 ready", 16'(insn_ready), 16'd1);
    endtask

    task automatic t_direct;
        set_page(9'd4);
        lar(3'd0, 1'b0, 2'b00, 1'b0, 3'd0, 7'd10, "R2 R3 direct p4");
        set_page(9'd0);
        lar(3'd4, 1'b0, 2'b00, 1'b0, 3'd0, 7'd5, "R3 direct p0");
        chk("R4 value", m_ar[4], 16'd617);
    endtask

    task automatic t_indirect;
        lar(3'd1, 1'b1, 2'b00, 1'b1, 3'd4, 7'd0, "R9 ptr reload");
        lar(3'd4, 1'b1, 2'b01, 1'b0, 3'd0, 7'd0, "R8 self dec");
        chk("R8 kept 0x32", m_ar[4], 16'h0032);
        lar(3'd2, 1'b1, 2'b10, 1'b0, 3'd0, 7'd0, "R7 inc");
        lar(3'd3, 1'b1, 2'b01, 1'b1, 3'd5, 7'd0, "R7 dec");
        lar(3'd6, 1'b1, 2'b01, 1'b0, 3'd0, 7'd0, "R7 wrap down");
        lar(3'd6, 1'b1, 2'b10, 1'b0, 3'd0, 7'd0, "R7 wrap up");
        lar(3'd7, 1'b1, 2'b11, 1'b1, 3'd7, 7'd0, "R7 code11");
        lar(3'd7, 1'b1, 2'b10, 1'b0, 3'd0, 7'd0, "R8 self inc");
    endtask

    task automatic t_illegal;
        @(negedge clk);
        insn_word = 16'h3F00; insn_valid = 1'b1;
        #1;
        chk("R10 no read", 16'(mem_rd), 16'd0);
        @(negedge clk);
        insn_valid = 1'b0;
        m_pc = m_pc + 16'd1;
        chk("R10 flag", 16'(illegal), 16'd1);
        chk("R10 ready", 16'(insn_ready), 16'd1);
        chk_state("R10 R5 no change");
        @(negedge clk);
        chk("R10 flag one cycle", 16'(illegal), 16'd0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 37 + 5);
        mem[522] = 16'h0018;
        mem[5]   = 16'd617;
        mem[617] = 16'h0032;
        mem[0]   = 16'h0000;
        for (int i = 0; i < 8; i++) m_ar[i] = '0;
        m_arp = '0; m_page = '0; m_pc = '0;
        rst = 1'b1; insn_valid = 1'b0; insn_word = '0;
        page_we = 1'b0; page_din = '0; ar_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_indirect();
        t_illegal();
        lar(3'd5, 1'b0, 2'b00, 1'b0, 3'd0, 7'd100, "R4 after illegal");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule